// File: doc/BRIEF.md
# USB Control Endpoint Transaction Handler

This block holds the device-side state of one USB control endpoint. Toward the link side it takes decoded token indications (SETUP, OUT, IN) and the data bytes and end-of-packet marks of each received data packet. It returns, one cycle later, a handshake decision or a description of the IN data packet to send. Toward firmware it offers a small register port with four addresses: status/command, FIFO fill level, FIFO data and interrupt enable.

All received and transmitted payload passes through one single-bank byte FIFO. A received SETUP packet is always taken and acknowledged. It then locks the bank through a setup-received flag. Until firmware has drained the eight setup bytes and cleared that flag, every OUT packet is refused, so the request cannot be overwritten.

The block tracks the data toggle across the data stage. It forces DATA1 on the zero-length status IN of a control write and accepts a zero-length status OUT. A new SETUP aborts whatever transfer is in progress.

Top module: `usb_ctrl_ep`

## Requirements
- R1: After reset the status byte (address 0) reads 0, the FIFO count (address 1) reads 0, and `irq`, `hs_valid` and `in_valid` are low.
- R2: A SETUP token (tok_kind 0) followed by its data bytes and an end of packet stores the bytes in the FIFO. One cycle after `rx_eop`, `hs_valid` is high with `hs_ack`=1 (ACK). In the same cycle status bit 0 (setup received) is set and status bit 4 (data toggle) reads 1.
- R3: `irq` is high exactly while status bit 0 and the interrupt enable (address 3, bit 0 of the written value; status bit 5) are both set.
- R4: Writing address 0 with bit 0 set clears the setup-received flag only when the FIFO count is 0. Otherwise the flag is kept and status bit 3 (clear ignored) is set. A successful clear resets bit 3.
- R5: An OUT token (tok_kind 1) while the setup-received flag is set is answered with NAK (`hs_ack`=0), and its bytes are not stored.
- R6: An OUT is answered with ACK only when the setup flag, the OUT-received flag (status bit 1) and the transmit-ready flag (status bit 2) are all clear and the FIFO is empty. An accepted OUT stores its bytes, sets bit 1 and inverts the toggle. Any other OUT gets NAK.
- R7: An IN token (tok_kind 2) while transmit-ready is clear gives `in_valid`=1 with `in_nak`=1 one cycle later.
- R8: An IN token while transmit-ready is set gives `in_valid`=1, `in_nak`=0 and `in_len` equal to the FIFO count. Bytes then leave in write order on `tx_pop`. A `host_ack` empties the FIFO, clears transmit-ready and inverts the toggle.
- R9: `in_pid` (0 = DATA0, 1 = DATA1) equals the toggle, except after an accepted OUT in the current transfer, when it is forced to 1. A zero-length status IN after a control write therefore goes out as DATA1.
- R10: A zero-length OUT on a free bank is acknowledged and sets status bit 1 with the FIFO count staying 0.
- R11: A SETUP token empties the FIFO and clears transmit-ready, OUT-received and clear-ignored before the new bytes arrive.
- R12: Reading address 2 returns the FIFO head and removes it. Bytes leave in arrival order. Writing address 2 appends a byte while transmit-ready is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | 0 SETUP, 1 OUT, 2 IN, 3 none |
| rx_valid | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | End of received data packet |
| hs_valid | output | 1 | Handshake decision strobe |
| hs_ack | output | 1 | 1 ACK, 0 NAK |
| in_valid | output | 1 | IN response strobe |
| in_nak | output | 1 | IN answered with NAK |
| in_pid | output | 1 | Data PID of IN packet, 1 = DATA1 |
| in_len | output | CW | IN payload length |
| tx_pop | input | 1 | Take one byte of IN payload |
| tx_byte | output | 8 | Current IN payload byte |
| host_ack | input | 1 | Host acknowledged the IN packet |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | Endpoint interrupt |

## Verification
The handshake and the IN response are registered, so each appears in the cycle after the `rx_eop` or token that caused it. Status flags, the toggle and the FIFO count change on that same edge. `reg_rdata`, `tx_byte` and `irq` follow the registered state combinationally. The bench drives and samples on falling edges. It reads the handshake and IN response at the first falling edge after the strobe, and reads registers a short delay after setting the address, before the edge that would pop the FIFO.

// File: rtl/ctrl_ep_pkg.sv
package ctrl_ep_pkg;
    typedef enum logic [1:0] {TOK_SETUP = 2'd0, TOK_OUT = 2'd1, TOK_IN = 2'd2, TOK_NONE = 2'd3} tok_e;
    typedef enum logic [1:0] {XF_IDLE, XF_SETUP, XF_OUT, XF_DROP} xfer_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_IEN  = 2'd3;

    typedef struct packed {
        xfer_e xfer;
        logic  setup_flag;
        logic  out_rcvd;
        logic  tx_rdy;
        logic  clr_ign;
        logic  toggle;
        logic  ie;
        logic  saw_out;
        logic  hs_valid;
        logic  hs_ack;
        logic  in_valid;
        logic  in_nak;
        logic  in_pid;
    } ep_state_t;
endpackage

// File: rtl/ctrl_ep_fifo.sv
module ctrl_ep_fifo #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic [7:0]    head
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_d, wr_q, rd_d, rd_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push = push && (cnt_q != CW'(DEPTH)) && !flush;
        do_pop  = pop && (cnt_q != '0) && !flush;
        wr_d    = wr_q;
        rd_d    = rd_q;
        cnt_d   = cnt_q;
        if (flush) begin
            wr_d  = '0;
            rd_d  = '0;
            cnt_d = '0;
        end else begin
            if (do_push) wr_d = step(wr_q);
            if (do_pop)  rd_d = step(rd_q);
            cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end

    assign count = cnt_q;
    assign head  = mem[rd_q];
endmodule

// File: rtl/ctrl_ep_rdmux.sv
module ctrl_ep_rdmux #(
    parameter int CW = 5
) (
    input  logic [1:0]    addr,
    input  logic [7:0]    status,
    input  logic [CW-1:0] count,
    input  logic [7:0]    head,
    output logic [7:0]    rdata
);
    import ctrl_ep_pkg::*;

    always_comb begin
        case (addr)
            A_CTRL:  rdata = status;
            A_CNT:   rdata = 8'(count);
            A_DATA:  rdata = head;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/usb_ctrl_ep.sv
module usb_ctrl_ep #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_valid,
    input  logic [1:0]    tok_kind,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          rx_eop,
    output logic          hs_valid,
    output logic          hs_ack,
    output logic          in_valid,
    output logic          in_nak,
    output logic          in_pid,
    output logic [CW-1:0] in_len,
    input  logic          tx_pop,
    output logic [7:0]    tx_byte,
    input  logic          host_ack,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          irq
);
    import ctrl_ep_pkg::*;

    ep_state_t     st_d, st_q;
    logic [CW-1:0] len_d, len_q;
    logic [CW-1:0] fifo_count;
    logic [7:0]    fifo_head;
    logic          flush, push, pop, rx_push;
    logic [7:0]    push_data;
    logic          bank_busy;
    logic [7:0]    status;

    always_comb begin
        st_d          = st_q;
        len_d         = len_q;
        st_d.hs_valid = 1'b0;
        st_d.in_valid = 1'b0;
        flush         = 1'b0;
        bank_busy     = st_q.setup_flag || st_q.out_rcvd || st_q.tx_rdy || (fifo_count != '0);
        rx_push       = rx_valid && (st_q.xfer == XF_SETUP || st_q.xfer == XF_OUT);
        push          = rx_push || (reg_wr && reg_addr == A_DATA && !st_q.tx_rdy);
        push_data     = rx_push ? rx_byte : reg_wdata;
        pop           = (reg_rd && reg_addr == A_DATA && !st_q.tx_rdy)
                      || (tx_pop && st_q.tx_rdy);

        // firmware commands
        if (reg_wr && reg_addr == A_CTRL) begin
            if (reg_wdata[0]) begin
                if (fifo_count != '0) begin
                    st_d.clr_ign = 1'b1;
                end else begin
                    st_d.setup_flag = 1'b0;
                    st_d.clr_ign    = 1'b0;
                end
            end
            if (reg_wdata[1]) st_d.out_rcvd = 1'b0;
            if (reg_wdata[2]) st_d.tx_rdy   = 1'b1;
        end
        if (reg_wr && reg_addr == A_IEN) st_d.ie = reg_wdata[0];

        // IN packet acknowledged by the host
        if (host_ack && st_q.tx_rdy) begin
            st_d.tx_rdy = 1'b0;
            st_d.toggle = ~st_d.toggle;
            flush       = 1'b1;
        end

        // token decode
        if (tok_valid) begin
            case (tok_kind)
                TOK_SETUP: begin
                    st_d.xfer     = XF_SETUP;
                    st_d.tx_rdy   = 1'b0;
                    st_d.out_rcvd = 1'b0;
                    st_d.clr_ign  = 1'b0;
                    st_d.saw_out  = 1'b0;
                    flush         = 1'b1;
                end
                TOK_OUT: st_d.xfer = bank_busy ? XF_DROP : XF_OUT;
                TOK_IN: begin
                    st_d.in_valid = 1'b1;
                    st_d.in_nak   = !st_q.tx_rdy;
                    st_d.in_pid   = st_q.tx_rdy && (st_q.saw_out || st_q.toggle);
                    len_d         = st_q.tx_rdy ? fifo_count : '0;
                end
                default: ;
            endcase
        end

        // end of a received data packet
        if (rx_eop && st_q.xfer != XF_IDLE) begin
            st_d.hs_valid = 1'b1;
            st_d.hs_ack   = (st_q.xfer != XF_DROP);
            st_d.xfer     = XF_IDLE;
            if (st_q.xfer == XF_SETUP) begin
                st_d.setup_flag = 1'b1;
                st_d.toggle     = 1'b1;
            end
            if (st_q.xfer == XF_OUT) begin
                st_d.out_rcvd = 1'b1;
                st_d.saw_out  = 1'b1;
                st_d.toggle   = ~st_q.toggle;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '{xfer: XF_IDLE, default: 1'b0};
            len_q <= '0;
        end else begin
            st_q  <= st_d;
            len_q <= len_d;
        end
    end

    ctrl_ep_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .count     (fifo_count),
        .head      (fifo_head)
    );

    assign status = {2'b00, st_q.ie, st_q.toggle, st_q.clr_ign,
                     st_q.tx_rdy, st_q.out_rcvd, st_q.setup_flag};

    ctrl_ep_rdmux #(.CW(CW)) u_rdmux (
        .addr   (reg_addr),
        .status (status),
        .count  (fifo_count),
        .head   (fifo_head),
        .rdata  (reg_rdata)
    );

    assign hs_valid = st_q.hs_valid;
    assign hs_ack   = st_q.hs_ack;
    assign in_valid = st_q.in_valid;
    assign in_nak   = st_q.in_nak;
    assign in_pid   = st_q.in_pid;
    assign in_len   = len_q;
    assign tx_byte  = fifo_head;
    assign irq      = st_q.setup_flag && st_q.ie;
endmodule

// File: rtl/ctrl_ep_chk.sv
module ctrl_ep_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tok_valid,
    input logic [1:0]    tok_kind,
    input logic          rx_valid,
    input logic          rx_eop,
    input logic          host_ack,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [7:0]    reg_wdata,
    input logic          hs_valid,
    input logic          hs_ack,
    input logic          setup_flag,
    input logic          out_rcvd,
    input logic          tx_rdy,
    input logic          clr_ign,
    input logic          toggle,
    input logic          dropping,
    input logic [CW-1:0] count
);
    // R2
    setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_flag) |-> hs_valid && hs_ack && toggle);

    // R4
    clear_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[0] && count != '0 && !tok_valid && !rx_eop)
        |=> clr_ign && (setup_flag == $past(setup_flag)));

    // R5
    drop_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dropping && rx_valid) |=> count <= $past(count));

    // R6
    out_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_rcvd) |-> hs_valid && hs_ack && (toggle != $past(toggle)));

    // R8
    in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && tx_rdy && !tok_valid && !reg_wr && !rx_eop)
        |=> !tx_rdy && count == '0 && (toggle != $past(toggle)));

    // R11
    setup_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 2'd0) |=> !tx_rdy && !out_rcvd && !clr_ign && count == '0);
endmodule

bind usb_ctrl_ep ctrl_ep_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_valid  (tok_valid),
    .tok_kind   (tok_kind),
    .rx_valid   (rx_valid),
    .rx_eop     (rx_eop),
    .host_ack   (host_ack),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .hs_valid   (hs_valid),
    .hs_ack     (hs_ack),
    .setup_flag (st_q.setup_flag),
    .out_rcvd   (st_q.out_rcvd),
    .tx_rdy     (st_q.tx_rdy),
    .clr_ign    (st_q.clr_ign),
    .toggle     (st_q.toggle),
    .dropping   (st_q.xfer == ctrl_ep_pkg::XF_DROP),
    .count      (fifo_count)
);

// File: tb/usb_ctrl_ep_tb.sv
module usb_ctrl_ep_tb;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tok_valid = 1'b0;
    logic [1:0]    tok_kind = 2'd3;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          rx_eop = 1'b0;
    logic          hs_valid, hs_ack, in_valid, in_nak, in_pid;
    logic [CW-1:0] in_len;
    logic          tx_pop = 1'b0;
    logic [7:0]    tx_byte;
    logic          host_ack = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          irq;

    int errs = 0;
    int checks = 0;
    logic c_hv, c_ha, c_iv, c_in, c_ip;
    int   c_il;
    logic [7:0] v;

    always #10 clk = ~clk;

    usb_ctrl_ep u_dut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eop(rx_eop),
        .hs_valid(hs_valid), .hs_ack(hs_ack), .in_valid(in_valid), .in_nak(in_nak),
        .in_pid(in_pid), .in_len(in_len), .tx_pop(tx_pop), .tx_byte(tx_byte),
        .host_ack(host_ack), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tok(input logic [1:0] k);
        @(negedge clk); tok_valid = 1'b1; tok_kind = k;
        @(negedge clk); tok_valid = 1'b0; tok_kind = 2'd3;
        c_iv = in_valid; c_in = in_nak; c_ip = in_pid; c_il = int'(in_len);
    endtask

    task automatic data(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_byte = 8'(base + 3 * i);
        end
        @(negedge clk); rx_valid = 1'b0; rx_eop = 1'b1;
        @(negedge clk); rx_eop = 1'b0;
        c_hv = hs_valid; c_ha = hs_ack;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic txpop(output logic [7:0] d);
        @(negedge clk); tx_pop = 1'b1;
        #1 d = tx_byte;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic hack();
        @(negedge clk); host_ack = 1'b1;
        @(negedge clk); host_ack = 1'b0;
    endtask

    task automatic setup_pkt(input int base, input string req);
        tok(2'd0);
        data(8, base);
        chk({req, " setup handshake valid"}, c_hv, 1);
        chk({req, " setup ACK"}, c_ha, 1);
    endtask

    task automatic t_reset();
        rd(2'd0, v); chk("R1 status", v, 0);
        rd(2'd1, v); chk("R1 count", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 hs_valid", hs_valid, 0);
        chk("R1 in_valid", in_valid, 0);
    endtask

    task automatic t_control_write();
        setup_pkt(8'h10, "R2");
        rd(2'd0, v); chk("R2 status setup+toggle", v, 8'h11);
        chk("R3 irq off while disabled", irq, 0);
        wr(2'd3, 8'h01);
        chk("R3 irq on", irq, 1);
        tok(2'd1); data(2, 8'hA0);
        chk("R5 locked OUT handshake valid", c_hv, 1);
        chk("R5 locked OUT NAK", c_ha, 0);
        rd(2'd1, v); chk("R5 count unchanged", v, 8);
        wr(2'd0, 8'h01);
        rd(2'd0, v); chk("R4 early clear ignored", v, 8'h39);
        chk("R3 irq held", irq, 1);
        for (int i = 0; i < 8; i++) begin
            rd(2'd2, v); chk("R12 setup byte order", v, 8'h10 + 3 * i);
        end
        wr(2'd0, 8'h01);
        rd(2'd0, v); chk("R4 clear after drain", v, 8'h30);
        chk("R3 irq drops", irq, 0);
        tok(2'd1); data(3, 8'h50);
        chk("R6 OUT ACK", c_ha, 1);
        rd(2'd0, v); chk("R6 out flag and toggle", v, 8'h22);
        rd(2'd1, v); chk("R6 count", v, 3);
        tok(2'd1); data(1, 8'h77);
        chk("R6 busy OUT NAK", c_ha, 0);
        for (int i = 0; i < 3; i++) begin
            rd(2'd2, v); chk("R6 OUT bytes", v, 8'h50 + 3 * i);
        end
        wr(2'd0, 8'h02);
        tok(2'd2);
        chk("R7 IN valid", c_iv, 1);
        chk("R7 IN NAK", c_in, 1);
        wr(2'd0, 8'h04);
        tok(2'd2);
        chk("R9 status IN not NAK", c_in, 0);
        chk("R9 status IN length", c_il, 0);
        chk("R9 status IN DATA1", c_ip, 1);
        hack();
        rd(2'd0, v); chk("R8 after ack", v, 8'h30);
    endtask

    task automatic t_control_read();
        setup_pkt(8'h80, "R2");
        for (int i = 0; i < 8; i++) rd(2'd2, v);
        wr(2'd0, 8'h01);
        for (int i = 0; i < 4; i++) wr(2'd2, 8'hC0 + 8'(i));
        rd(2'd1, v); chk("R12 firmware write count", v, 4);
        wr(2'd0, 8'h04);
        tok(2'd2);
        chk("R8 IN not NAK", c_in, 0);
        chk("R8 IN length", c_il, 4);
        chk("R8 first IN DATA1", c_ip, 1);
        for (int i = 0; i < 4; i++) begin
            txpop(v); chk("R8 IN byte order", v, 8'hC0 + i);
        end
        hack();
        rd(2'd0, v); chk("R8 toggle to 0, ready clear", v, 8'h20);
        rd(2'd1, v); chk("R8 FIFO emptied", v, 0);
        wr(2'd2, 8'hE1); wr(2'd2, 8'hE2); wr(2'd0, 8'h04);
        tok(2'd2);
        chk("R8 second IN length", c_il, 2);
        chk("R9 second IN DATA0", c_ip, 0);
        txpop(v); txpop(v);
        hack();
        rd(2'd0, v); chk("R8 toggle back to 1", v, 8'h30);
        tok(2'd1); data(0, 0);
        chk("R10 status OUT ACK", c_ha, 1);
        rd(2'd0, v); chk("R10 out flag set", v, 8'h22);
        rd(2'd1, v); chk("R10 count zero", v, 0);
    endtask

    task automatic t_abort();
        setup_pkt(8'h20, "R11");
        rd(2'd0, v); chk("R11 out flag cleared by SETUP", v, 8'h31);
        for (int i = 0; i < 8; i++) rd(2'd2, v);
        wr(2'd0, 8'h01);
        for (int i = 0; i < 3; i++) wr(2'd2, 8'h90 + 8'(i));
        wr(2'd0, 8'h04);
        rd(2'd0, v); chk("R11 ready before abort", v, 8'h34);
        setup_pkt(8'h60, "R11");
        rd(2'd0, v); chk("R11 ready cleared", v, 8'h31);
        rd(2'd1, v); chk("R11 count is new setup", v, 8);
        rd(2'd2, v); chk("R11 head is new setup", v, 8'h60);
        chk("R3 irq with enable", irq, 1);
        wr(2'd3, 8'h00);
        chk("R3 irq masked", irq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_control_write();
        t_control_read();
        t_abort();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule